// File: doc/BRIEF.md
# Aliasing-Based Memory Size Probe

This block is a small bus master that measures how much memory answers in a window starting at a fixed base address. After a start pulse it clears a reference word at the base, then writes a fixed signature at increasing offsets. After each signature write it reads the reference word back. A memory smaller than the probed offset wraps its address, so the signature lands on the reference. When that happens, the offset just written is the size.

If the reference stays zero all the way up to the scan ceiling, the ceiling is reported instead. The result appears with a one-cycle done pulse. The block talks to memory over a plain request/acknowledge port with 32-bit data. A request stays high until it is acknowledged and then stays low for at least one cycle. Boot or bring-up logic would run it once before handing memory to software.

Top module: `ram_size_probe`

## Requirements
- R1: After reset, mem_req_o and done_o are low and the block waits for start_i.
- R2: The first access after a start pulse is a write of 32'h0 to address BASE_ADDR.
- R3: Signature writes carry 32'hF2D4B698 and go to BASE_ADDR + FIRST_OFF + k*STEP_OFF for k = 0, 1, 2, … in ascending order (defaults 0x1000 and 0x1000).
- R4: Every signature write is followed directly by a read of address BASE_ADDR.
- R5: A nonzero value from that read ends the scan, and size_o reports the offset of the signature write just before it.
- R6: If no read returns nonzero, the scan stops before offset LIMIT_OFF (default 0x20000) and size_o reports LIMIT_OFF. With the defaults that takes 31 signature writes.
- R7: While mem_req_o is high and mem_ack_i is low, mem_req_o stays high the next cycle, and mem_addr_o, mem_we_o and mem_wdata_o do not change.
- R8: In the cycle after a request is acknowledged, mem_req_o is low.
- R9: done_o is high for exactly one cycle per scan, with size_o valid and mem_req_o low.
- R10: A start pulse that arrives while a scan is running has no effect: the scan ends with the same size and gives only one done pulse.
- R11: A nonzero value already stored at the reference word before start does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, ignored unless idle |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Access acknowledge |
| done_o | output | 1 | One-cycle result strobe |
| size_o | output | ADDR_W | Detected size in bytes |

## Verification
The checker watches the port handshake on every cycle: it checks that requests are held and stable until acknowledged (R7), that a low cycle follows each acknowledge (R8), that done is a single-cycle strobe with no request pending (R9), and that the write data and reported size stay in their legal set. Only the bench's aliasing memory model can show the ordered clear/write/read sequence and the size values (R2–R6). The same applies to a stale reference word (R11) and to a second start during a scan (R10), because these depend on what the memory returns.

// File: rtl/ram_probe_pkg.sv
package ram_probe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_WRITE,
    ST_READ,
    ST_NEXT,
    ST_DONE
  } probe_state_e;
endpackage

// File: rtl/probe_offset_gen.sv
module probe_offset_gen #(
  parameter int unsigned OFF_W     = 19,
  parameter int unsigned FIRST_OFF = 32'h1000,
  parameter int unsigned STEP_OFF  = 32'h1000,
  parameter int unsigned LIMIT_OFF = 32'h20000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  output logic [OFF_W-1:0] offset_o,
  output logic [OFF_W-1:0] next_o,
  output logic             last_o
);
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      off_q <= OFF_W'(FIRST_OFF);
    else if (load_i)  off_q <= OFF_W'(FIRST_OFF);
    else if (step_i)  off_q <= off_q + OFF_W'(STEP_OFF);
  end

  assign offset_o = off_q;
  assign next_o   = off_q + OFF_W'(STEP_OFF);
  // next probe would reach the ceiling
  assign last_o   = (next_o >= OFF_W'(LIMIT_OFF));
endmodule

// File: rtl/probe_bus_port.sv
module probe_bus_port #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              want_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              mem_ack_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              fire_o
);
  logic              req_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign fire_o = req_q & mem_ack_i;

  // launch only from a low cycle, so a gap follows every ack
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (req_q) begin
      if (mem_ack_i) req_q <= 1'b0;
    end else if (want_i) begin
      req_q   <= 1'b1;
      we_q    <= we_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  assign mem_req_o   = req_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
endmodule

// File: rtl/ram_size_probe.sv
module ram_size_probe
  import ram_probe_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 24,
  parameter int unsigned       DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int unsigned       FIRST_OFF = 32'h1000,
  parameter int unsigned       STEP_OFF  = 32'h1000,
  parameter int unsigned       LIMIT_OFF = 32'h20000,
  parameter logic [DATA_W-1:0] SIGNATURE = DATA_W'(32'hF2D4B698)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] size_o
);
  localparam int unsigned OFF_W = $clog2(LIMIT_OFF) + 2;

  probe_state_e      state_q, state_d;
  logic [ADDR_W-1:0] size_q, size_d;
  logic              load, step, last, fire, want, we;
  logic [OFF_W-1:0]  offset, next_off;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;

  probe_offset_gen #(
    .OFF_W(OFF_W), .FIRST_OFF(FIRST_OFF), .STEP_OFF(STEP_OFF), .LIMIT_OFF(LIMIT_OFF)
  ) i_offset (
    .clk_i, .rst_ni,
    .load_i  (load),
    .step_i  (step),
    .offset_o(offset),
    .next_o  (next_off),
    .last_o  (last)
  );

  assign want  = (state_q == ST_CLEAR) || (state_q == ST_WRITE) || (state_q == ST_READ);
  assign we    = (state_q != ST_READ);
  assign addr  = (state_q == ST_WRITE) ? BASE_ADDR + ADDR_W'(offset) : BASE_ADDR;
  assign wdata = (state_q == ST_CLEAR) ? '0 : SIGNATURE;

  probe_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bus (
    .clk_i, .rst_ni,
    .want_i     (want),
    .we_i       (we),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .mem_ack_i,
    .mem_req_o,
    .mem_we_o,
    .mem_addr_o,
    .mem_wdata_o,
    .fire_o     (fire)
  );

  always_comb begin
    state_d = state_q;
    size_d  = size_q;
    load    = 1'b0;
    step    = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start_i) begin state_d = ST_CLEAR; load = 1'b1; end
      ST_CLEAR: if (fire) state_d = ST_WRITE;
      ST_WRITE: if (fire) state_d = ST_READ;
      ST_READ: if (fire) begin
        if (mem_rdata_i != '0) begin
          // reference overwritten: address wrapped at this offset
          size_d  = ADDR_W'(offset);
          state_d = ST_DONE;
        end else begin
          state_d = ST_NEXT;
        end
      end
      ST_NEXT: begin
        step = 1'b1;
        if (last) begin
          size_d  = ADDR_W'(next_off);
          state_d = ST_DONE;
        end else begin
          state_d = ST_WRITE;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      size_q  <= '0;
    end else begin
      state_q <= state_d;
      size_q  <= size_d;
    end
  end

  assign done_o = (state_q == ST_DONE);
  assign size_o = size_q;
endmodule

// File: rtl/ram_probe_sva.sv
module ram_probe_sva #(
  parameter int unsigned       ADDR_W    = 24,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       FIRST_OFF = 32'h1000,
  parameter int unsigned       LIMIT_OFF = 32'h20000,
  parameter logic [DATA_W-1:0] SIGNATURE = DATA_W'(32'hF2D4B698)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ack_i,
  input logic              done_o,
  input logic [ADDR_W-1:0] size_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o); // R7
  AST_REQ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)); // R7
  AST_REQ_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> !mem_req_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o); // R9
  AST_SIZE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (size_o >= ADDR_W'(FIRST_OFF)) && (size_o <= ADDR_W'(LIMIT_OFF))); // R5
  AST_WDATA_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> (mem_wdata_o == '0) || (mem_wdata_o == SIGNATURE)); // R3
endmodule

bind ram_size_probe ram_probe_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIRST_OFF(FIRST_OFF),
  .LIMIT_OFF(LIMIT_OFF), .SIGNATURE(SIGNATURE)
) i_ram_probe_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
  .done_o(done_o), .size_o(size_o)
);

// File: tb/test_ram_size_probe.sv
`timescale 1ns/1ps
module test_ram_size_probe;
  localparam int unsigned ADDR_W = 24;
  localparam logic [23:0] BASE   = 24'h200000;
  localparam int unsigned STEP   = 32'h1000;
  localparam int unsigned LIMIT  = 32'h20000;
  localparam logic [31:0] SIG    = 32'hF2D4B698;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic mem_req_o, mem_we_o, mem_ack_i = 1'b0, done_o;
  logic [23:0] mem_addr_o, size_o;
  logic [31:0] mem_wdata_o, mem_rdata_i = '0;

  always #2 clk_i = ~clk_i;

  ram_size_probe #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE)) i_ram_size_probe (.*);

  int checks = 0, fails = 0;
  int unsigned msize = 32'h8000;
  logic [31:0] mem [64];
  int err_r2, err_r3, err_r4, err_r7, err_r8, nwrites, phase;
  int unsigned exp_off;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int unsigned exp_size(input int unsigned ms);
    return (ms < LIMIT) ? ms : LIMIT;
  endfunction

  function automatic int exp_writes(input int unsigned ms);
    return (ms < LIMIT) ? int'(ms / STEP) : int'(LIMIT / STEP) - 1;
  endfunction

  function automatic int midx(input logic [23:0] a);
    return int'((32'(a - BASE) % msize) / STEP);
  endfunction

  // memory model with random latency; checks access order
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk_i);
      if (mem_ack_i) mem_ack_i = 1'b0;
      else if (mem_req_o) begin
        if (lat == 0) begin
          if (phase == 0) begin
            if (!(mem_we_o && mem_addr_o == BASE && mem_wdata_o == 0)) err_r2++;
            mem[midx(mem_addr_o)] = mem_wdata_o;
            phase = 1;
          end else if (phase == 1) begin
            if (!(mem_we_o && mem_addr_o == BASE + 24'(exp_off) && mem_wdata_o == SIG)) err_r3++;
            mem[midx(mem_addr_o)] = mem_wdata_o;
            nwrites++;
            phase = 2;
          end else begin
            if (!(!mem_we_o && mem_addr_o == BASE)) err_r4++;
            mem_rdata_i = mem[midx(mem_addr_o)];
            exp_off += STEP;
            phase = 1;
          end
          mem_ack_i = 1'b1;
          lat = $urandom % 3;
        end else lat--;
      end
    end
  end

  // handshake monitor
  initial begin
    logic p_req = 0, p_ack = 0, p_we = 0;
    logic [23:0] p_addr = 0;
    forever begin
      @(negedge clk_i); #1;
      if (rst_ni) begin
        if (p_req && !p_ack && !(mem_req_o && mem_addr_o == p_addr && mem_we_o == p_we)) err_r7++;
        if (p_req && p_ack && mem_req_o) err_r8++;
      end
      p_req = mem_req_o; p_ack = mem_ack_i; p_addr = mem_addr_o; p_we = mem_we_o;
    end
  end

  task automatic run_scan(input int unsigned ms, input bit restart);
    int n = 0;
    msize = ms;
    foreach (mem[i]) mem[i] = $urandom | 32'h1;  // stale nonzero reference, R11
    err_r2 = 0; err_r3 = 0; err_r4 = 0; err_r7 = 0; err_r8 = 0;
    nwrites = 0; phase = 0; exp_off = STEP;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    if (restart) begin
      repeat (15) @(negedge clk_i);
      start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
    end
    while (!done_o && n < 5000) begin @(negedge clk_i); n++; end
    check(done_o, "R9 done seen", done_o, 1);
    check(size_o == 24'(exp_size(ms)), (ms < LIMIT) ? "R5 R11 size" : "R6 size", size_o, exp_size(ms));
    check(!mem_req_o, "R9 req low at done", mem_req_o, 0);
    @(negedge clk_i);
    check(!done_o, "R9 one-cycle done", done_o, 0);
    check(nwrites == exp_writes(ms), "R6 write count", nwrites, exp_writes(ms));
    check(err_r2 == 0, "R2 clear access", err_r2, 0);
    check(err_r3 == 0, "R3 signature order", err_r3, 0);
    check(err_r4 == 0, "R4 readback", err_r4, 0);
    check(err_r7 == 0, "R7 hold", err_r7, 0);
    check(err_r8 == 0, "R8 gap", err_r8, 0);
    if (restart) begin
      int extra = 0;
      repeat (40) begin @(negedge clk_i); if (done_o || mem_req_o) extra++; end
      check(extra == 0, "R10 restart ignored", extra, 0);
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk_i);
    check(!mem_req_o && !done_o, "R1 reset state", {mem_req_o, done_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(!mem_req_o && !done_o, "R1 idle after reset", {mem_req_o, done_o}, 0);
    run_scan(32'h1000, 0);
    run_scan(32'h2000, 0);
    run_scan(32'h10000, 0);
    run_scan(32'h20000, 0);
    run_scan(32'h40000, 0);
    run_scan(32'h8000, 1);
    run_scan(32'h40000, 1);
    for (int i = 0; i < 8; i++) run_scan(32'h1000 << ($urandom % 7), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule